// File: doc/BRIEF.md
# Triggered One-Shot Strobe Timer

This block is a single-channel countdown timer that emits one active-low strobe, one clock wide, a programmed number of clocks after a trigger. The count is written a byte at a time through a write strobe and data byte. It is assembled least-significant byte first. A mode input chooses where the trigger comes from. In software mode, writing the final byte of the count starts the sequence. In gate mode, a rising edge on the gate input starts it.

On the clock after a trigger, the counter loads the programmed value, and that clock does not decrement. A count of N therefore produces the strobe N+1 clocks after the triggering edge. After the strobe, the counter keeps running and wraps around silently until the next trigger. Each mode has its own rule for what happens when the count is rewritten or the trigger is repeated.

Top module: `oneshot_strobe_timer`

## Requirements
- R1: After reset, `strobe_n` is high. With no count written and no gate edge, it stays high in both modes.
- R2: A count is two byte writes: the low byte first, then the high byte. A byte written alone (the low byte) starts nothing and does not disturb a sequence in progress. The full 16-bit value takes effect only with the high-byte write.
- R3: With `mode` = 0 (software) and `gate` high, the write sampled at clock edge k that completes the count N loads the counter at edge k+1. `strobe_n` is low for exactly one clock after edge k+1+N and high again after the next edge.
- R4: In software mode, `gate` low stops the decrement and never drives `strobe_n` itself. Each clock with `gate` low after the load edge delays the strobe by one clock.
- R5: In software mode, completing a new count while a sequence runs reloads the counter on the next clock. The strobe then comes N+1 clocks after that write.
- R6: With `mode` = 1 (gate), a clock edge at which `gate` is high, when it was low at the edge before, is a trigger. The counter loads at the next edge, and the strobe comes N+1 clocks after the trigger edge. The level of `gate` after the trigger does not matter.
- R7: In gate mode, every new trigger reloads the count. The strobe comes N+1 clocks after the latest trigger.
- R8: In gate mode, writing a count neither starts a sequence nor disturbs one in progress. The next trigger loads the newly written value.
- R9: Each trigger produces at most one strobe. After it, the counter wraps and no further strobe appears until another trigger.
- R10: A count of 0 acts as 65536, so the strobe comes 65537 clocks after the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | Trigger source: 0 software write, 1 gate rising edge |
| wr_en | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte, low byte then high byte |
| gate | input | 1 | Count enable in software mode; trigger in gate mode |
| strobe_n | output | 1 | Active-low one-clock strobe |

## Verification
The assertions assume that `gate`, `wr_en` and `mode` are already synchronous to `clk`. They also assume that count bytes arrive in complete low/high pairs, so the byte pointer never drifts out of phase with the writer. The bench drives every input on the falling edge, changes `mode` only when no sequence is armed, and always writes counts as pairs. The one exception is a deliberate lone low byte, which is completed later by its high byte. Before each gate-mode trigger, the bench holds `gate` low for at least one edge, so that every intended trigger is a clean rising edge.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;
    typedef enum logic {
        TRIG_SOFT = 1'b0,
        TRIG_GATE = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/ost_count_assembler.sv
module ost_count_assembler #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  value_o,
    output logic              commit_o
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] shift;
        logic [CNT_W-1:0] value;
        logic             commit;
    } asm_t;

    asm_t q, d;
    logic [CNT_W-1:0] shifted;

    always_comb begin
        d       = q;
        d.commit = 1'b0;
        shifted = {wr_data_i, q.shift[CNT_W-1:BYTE_W]};
        if (wr_en_i) begin
            d.shift = shifted;
            if (q.idx == LAST_IDX) begin
                d.idx    = '0;
                d.value  = shifted;
                d.commit = 1'b1;
            end else begin
                d.idx = q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign value_o  = q.value;
    assign commit_o = q.commit;

    // R2: a byte that does not complete the word never commits
    p_partial_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && q.idx != LAST_IDX) |=> !q.commit);
    // R2: the assembled value only moves on a completing write
    p_value_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(q.value));
endmodule

// File: rtl/ost_trigger_unit.sv
module ost_trigger_unit
    import strobe_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode_i,
    input  logic       gate_i,
    input  logic       commit_i,
    output logic       load_o,
    output logic       count_en_o
);
    typedef struct packed {
        logic gate;
        logic rise;
    } trg_t;

    trg_t q, d;

    always_comb begin
        d      = q;
        d.gate = gate_i;
        d.rise = gate_i & ~q.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{gate: 1'b1, rise: 1'b0};
        else        q <= d;
    end

    always_comb begin
        if (mode_i == TRIG_GATE) begin
            load_o     = q.rise;
            count_en_o = 1'b1;
        end else begin
            load_o     = commit_i;
            count_en_o = gate_i;
        end
    end

    // R6: a detected edge implies gate was high at the edge before
    p_edge_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |-> $past(gate_i));
    // R6: two consecutive detections are impossible
    p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |=> !q.rise);
endmodule

// File: rtl/ost_countdown.sv
module ost_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             strobe_n_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             strobe_n;
    } cd_t;

    cd_t q, d;

    always_comb begin
        d          = q;
        d.strobe_n = 1'b1;
        if (load_i) begin
            d.cnt   = value_i;
            d.armed = 1'b1;
        end else if (en_i) begin
            d.cnt = q.cnt - CNT_W'(1);
            if (q.armed && q.cnt == CNT_W'(1)) begin
                d.strobe_n = 1'b0;
                d.armed    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, armed: 1'b0, strobe_n: 1'b1};
        else        q <= d;
    end

    assign strobe_n_o = q.strobe_n;

    // R3: the strobe lasts exactly one clock
    p_single_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !q.strobe_n |=> q.strobe_n);
    // R4: with counting disabled the count holds and no strobe appears
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> ($stable(q.cnt) && q.strobe_n));
    // R5: a load takes the offered value and arms the channel
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.cnt == $past(value_i) && q.armed));
    // R9: no strobe without an armed sequence
    p_no_strobe_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.armed && !load_i) |=> q.strobe_n);
endmodule

// File: rtl/oneshot_strobe_timer.sv
module oneshot_strobe_timer
    import strobe_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              gate,
    output logic              strobe_n
);
    logic [CNT_W-1:0] count_val;
    logic             commit;
    logic             load;
    logic             count_en;
    trig_mode_e       trig_mode;

    assign trig_mode = trig_mode_e'(mode);

    ost_count_assembler #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .value_o  (count_val),
        .commit_o (commit)
    );

    ost_trigger_unit u_trg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (trig_mode),
        .gate_i    (gate),
        .commit_i  (commit),
        .load_o    (load),
        .count_en_o(count_en)
    );

    ost_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .en_i      (count_en),
        .value_i   (count_val),
        .strobe_n_o(strobe_n)
    );

    // R8: in gate mode a count write alone never loads the counter
    p_write_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && $past(wr_en) && !$past(gate)) |-> !load);
endmodule

// File: tb/test_oneshot_strobe_timer.sv
module test_oneshot_strobe_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       gate = 1'b0;
    logic       strobe_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    oneshot_strobe_timer i_oneshot_strobe_timer (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en),
        .wr_data(wr_data), .gate(gate), .strobe_n(strobe_n)
    );

    // {mode, count}; expected delay is count+1 clocks after the trigger
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'd1}, {1'b0, 16'd2}, {1'b0, 16'd7}, {1'b0, 16'd261},
        {1'b1, 16'd1}, {1'b1, 16'd3}, {1'b1, 16'd50}, {1'b1, 16'd300}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_count(input int n);
        wr_byte(n[7:0]);
        wr_byte(n[15:8]);
    endtask

    task automatic fire_gate();
        gate = 1'b1;
        @(negedge clk);
        gate = 1'b0;
    endtask

    task automatic wait_low(input int max, output int got);
        got = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (!strobe_n) begin
                got = i;
                break;
            end
        end
    endtask

    task automatic expect_strobe(input int exp, input string req);
        int got;
        wait_low(exp + 8, got);
        check(got == exp, req, got, exp);
        @(negedge clk);
        check(strobe_n == 1'b1, {req, " width"}, int'(strobe_n), 1);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!strobe_n) lows++;
        end
        check(lows == 0, req, lows, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(strobe_n == 1'b1, "R1 reset", int'(strobe_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        expect_quiet(20, "R1 idle software");
        mode = 1'b1;
        expect_quiet(20, "R1 idle gate");

        // table walk: R3 (software) and R6 (gate)
        for (int v = 0; v < NVEC; v++) begin
            mode = VEC[v][16];
            if (VEC[v][16] == 1'b0) begin
                gate = 1'b1;
                @(negedge clk);
                wr_count(int'(VEC[v][15:0]));
                expect_strobe(int'(VEC[v][15:0]) + 1, "R3 software delay");
            end else begin
                gate = 1'b0;
                @(negedge clk);
                wr_count(int'(VEC[v][15:0]));
                @(negedge clk);
                fire_gate();
                expect_strobe(int'(VEC[v][15:0]) + 1, "R6 gate delay");
            end
        end

        // R9: no second strobe after wrap
        expect_quiet(60, "R9 single strobe");

        // R2: a lone low byte starts nothing
        mode = 1'b0; gate = 1'b1;
        @(negedge clk);
        wr_byte(8'd3);
        expect_quiet(10, "R2 low byte alone");
        wr_byte(8'd0);
        expect_strobe(4, "R2 high byte completes");

        // R2: low byte mid-sequence does not disturb it
        wr_count(20);
        repeat (3) @(negedge clk);
        wr_byte(8'd2);
        expect_strobe(17, "R2 partial write mid-count");
        wr_byte(8'd0);
        expect_strobe(3, "R2 completed new count");

        // R4: gate low holds the count without touching the output
        gate = 1'b0;
        wr_count(10);
        expect_quiet(5, "R4 gate low output");
        gate = 1'b1;
        expect_strobe(10, "R4 gated delay");

        // R5: software rewrite restarts
        wr_count(20);
        repeat (5) @(negedge clk);
        wr_count(6);
        expect_strobe(7, "R5 rewrite");

        // R7: gate retrigger
        mode = 1'b1; gate = 1'b0;
        @(negedge clk);
        wr_count(12);
        fire_gate();
        repeat (6) @(negedge clk);
        fire_gate();
        expect_strobe(13, "R7 retrigger");

        // R8: count write in gate mode neither starts nor disturbs
        wr_count(5);
        expect_quiet(20, "R8 write no start");
        wr_count(30);
        fire_gate();
        repeat (4) @(negedge clk);
        wr_count(8);
        expect_strobe(25, "R8 write no disturb");
        fire_gate();
        expect_strobe(9, "R8 next trigger new value");

        // R10: zero means 65536
        mode = 1'b0; gate = 1'b1;
        @(negedge clk);
        wr_count(0);
        expect_strobe(65537, "R10 zero count");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule